// File: doc/BRIEF.md
# Configurable Pixel Input Capture

This block takes parallel video pixels from an external source and rebuilds them as a 24-bit-per-pixel stream in the main input clock domain. It supports three input modes. In the wide mode a whole 24-bit pixel arrives on every rising edge of the main clock. In the two narrow modes only the low 12 data pins carry pixels, and each pixel arrives as two halves. The half on the rising main-clock edge is the even half. The half on the following odd edge is the second half. That odd edge is either the falling edge of the main clock or a rising edge of a second, phase-locked clock.

In the narrow modes the top data pins are free. The block samples eight of them into a configuration capture register that a host can read. The block also registers the horizontal and vertical sync inputs so that they leave in step with the pixels. It passes an external control bit through only when an enable bit is set. A low level on the active-low power-down input blanks the pixel and valid outputs.

Top module: `pixcap_top`

## Requirements
- R1: With `wide_sel` = 1, `din[23:0]` sampled at rising `clk_main` edge k appears unchanged on `pix_out` after rising edge k+1.
- R2: With `wide_sel` = 0 and `dual_edge_sel` = 1, `pix_out[11:0]` is `din[11:0]` from rising edge k and `pix_out[23:12]` is `din[11:0]` from the next falling `clk_main` edge, both visible after rising edge k+1. `din[23:12]` never reaches `pix_out` in this mode.
- R3: With `wide_sel` = 0 and `dual_edge_sel` = 0, `pix_out[23:12]` is `din[11:0]` from the last rising `clk_odd` edge before rising edge k+1, and `pix_out[11:0]` comes from rising `clk_main` edge k. If `clk_odd` stops, the upper half keeps its last value.
- R4: Outside the two-clock mode, activity on `clk_odd` has no effect on `pix_out`.
- R5: `pix_vld` is 1 after rising edge k+1 exactly when `de_in` was 1 at edge k. A pixel whose even half was sampled with `de_in` = 0 is never flagged valid, so a single active cycle yields a single one-cycle pulse.
- R6: `hs_out` and `vs_out` equal `hs_in` and `vs_in` from two rising edges earlier, which is the same latency as the pixel.
- R7: With `wide_sel` = 0, `cfg_out` takes `din[23:16]` on every rising `clk_main` edge. With `wide_sel` = 1, it holds its value.
- R8: `ctl_out` equals `ctl_in` from two rising edges earlier when `ctl_pass_en` was 1 at that edge, and is 0 otherwise.
- R9: If `pd_n` is 0 at a rising edge, `pix_out` is 0 and `pix_vld` is 0 after that edge.
- R10: While `rst_n` is 0 at rising edges, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_main | input | 1 | Main input clock; rising edges are even edges |
| clk_odd | input | 1 | Second clock; its rising edges are odd edges in the two-clock mode |
| rst_n | input | 1 | Synchronous active-low reset |
| pd_n | input | 1 | Active-low power down; blanks pixel and valid |
| wide_sel | input | 1 | 1 = 24-bit single-edge mode, 0 = 12-bit modes |
| dual_edge_sel | input | 1 | In 12-bit modes: 1 = both main edges, 0 = second clock |
| din | input | 24 | Pixel data bus |
| de_in | input | 1 | Data enable, high while input data is valid |
| hs_in | input | 1 | Horizontal sync |
| vs_in | input | 1 | Vertical sync |
| ctl_in | input | 1 | External control bit |
| ctl_pass_en | input | 1 | Enable for passing `ctl_in` through |
| pix_out | output | 24 | Assembled pixel |
| pix_vld | output | 1 | One-cycle flag per valid assembled pixel |
| hs_out | output | 1 | Aligned horizontal sync |
| vs_out | output | 1 | Aligned vertical sync |
| ctl_out | output | 1 | Gated, aligned control bit |
| cfg_out | output | 8 | Configuration capture register |

## Verification
The embedded properties check on every main-clock cycle that the sync, control and valid outputs keep the two-edge latency relative to their inputs. They also check that power down blanks the pixel, that the configuration register tracks or holds according to the mode, and that the second-clock capture stays frozen outside its mode. How the two 12-bit halves combine into a pixel can only be shown by the bench scenarios. The same holds for immunity to a free-running or stopped second clock and for the exact pixel value in each mode, because these depend on falling-edge and second-clock timing that the main-clock properties do not see.

// File: rtl/pixcap_pkg.sv
// Shared types for the pixel input capture block.
// Assumes: mode pins are static while pixels flow.
package pixcap_pkg;

    typedef enum logic [1:0] {
        CAP_WIDE      = 2'd0,
        CAP_DUAL_EDGE = 2'd1,
        CAP_TWO_CLK   = 2'd2
    } cap_mode_e;

    // Map the two mode pins onto a capture mode.
    function automatic cap_mode_e decode_mode(input logic wide, input logic dual);
        if (wide)
            return CAP_WIDE;
        else if (dual)
            return CAP_DUAL_EDGE;
        else
            return CAP_TWO_CLK;
    endfunction

endpackage

// File: rtl/pixcap_even_stage.sv
// Even-edge sampler: registers the full data bus and the per-pixel side
// signals on each rising main-clock edge.
// Assumes: inputs meet setup to the rising edge of clk_main.
module pixcap_even_stage #(
    parameter int PIX_W = 24
) (
    input  logic             clk_main,
    input  logic             rst_n,
    input  logic [PIX_W-1:0] din,
    input  logic             de_in,
    input  logic             hs_in,
    input  logic             vs_in,
    input  logic             ctl_in,
    input  logic             ctl_pass_en,
    output logic [PIX_W-1:0] data_q,
    output logic             de_q,
    output logic             hs_q,
    output logic             vs_q,
    output logic             ctl_q
);

    // Sample the data bus and side signals on the even edge.
    always_ff @(posedge clk_main) begin
        if (!rst_n) begin
            data_q <= '0;
            de_q   <= 1'b0;
            hs_q   <= 1'b0;
            vs_q   <= 1'b0;
            ctl_q  <= 1'b0;
        end else begin
            data_q <= din;
            de_q   <= de_in;
            hs_q   <= hs_in;
            vs_q   <= vs_in;
            ctl_q  <= ctl_in & ctl_pass_en;
        end
    end

endmodule

// File: rtl/pixcap_odd_stage.sv
// Odd-edge sampler: latches the second 12-bit half on the falling main-clock
// edge (dual-edge mode) or on the rising second-clock edge (two-clock mode).
// Assumes: clk_odd is phase-locked to clk_main at the same frequency when used.
module pixcap_odd_stage
    import pixcap_pkg::*;
#(
    parameter int HALF_W = 12
) (
    input  logic              clk_main,
    input  logic              clk_odd,
    input  logic              rst_n,
    input  cap_mode_e         mode,
    input  logic [HALF_W-1:0] din_lo,
    output logic [HALF_W-1:0] hi_half
);

    logic [HALF_W-1:0] hi_fall;
    logic [HALF_W-1:0] hi_sec;

    // Falling-edge capture, enabled only in dual-edge mode.
    always_ff @(negedge clk_main) begin
        if (!rst_n)
            hi_fall <= '0;
        else if (mode == CAP_DUAL_EDGE)
            hi_fall <= din_lo;
    end

    // Second-clock capture, enabled only in two-clock mode.
    always_ff @(posedge clk_odd) begin
        if (!rst_n)
            hi_sec <= '0;
        else if (mode == CAP_TWO_CLK)
            hi_sec <= din_lo;
    end

    // Pick the odd half that belongs to the current mode.
    always_comb begin
        hi_half = (mode == CAP_TWO_CLK) ? hi_sec : hi_fall;
    end

    // R4: second-clock capture never moves outside the two-clock mode.
    p_odd_frozen_r4: assert property (@(posedge clk_main) disable iff (!rst_n)
        ($past(rst_n) && mode != CAP_TWO_CLK && $past(mode) != CAP_TWO_CLK)
        |-> $stable(hi_sec));

endmodule

// File: rtl/pixcap_cfg_reg.sv
// Configuration capture: in the 12-bit modes the spare upper data pins are
// sampled into a register; in the wide mode the register holds.
// Assumes: the host reads cfg_q as a quasi-static value.
module pixcap_cfg_reg #(
    parameter int CFG_W = 8
) (
    input  logic             clk_main,
    input  logic             rst_n,
    input  logic             narrow,
    input  logic [CFG_W-1:0] cfg_pins,
    output logic [CFG_W-1:0] cfg_q
);

    // Track the spare pins while the bus is narrow.
    always_ff @(posedge clk_main) begin
        if (!rst_n)
            cfg_q <= '0;
        else if (narrow)
            cfg_q <= cfg_pins;
    end

    // R7: tracking while narrow.
    p_cfg_track_r7: assert property (@(posedge clk_main) disable iff (!rst_n)
        ($past(rst_n) && $past(narrow)) |-> cfg_q == $past(cfg_pins));

    // R7: holding while wide.
    p_cfg_hold_r7: assert property (@(posedge clk_main) disable iff (!rst_n)
        ($past(rst_n) && !$past(narrow)) |-> $stable(cfg_q));

endmodule

// File: rtl/pixcap_assemble.sv
// Output stage: joins the even and odd halves (or passes the wide word),
// applies power-down blanking and re-times sync and control.
// Assumes: mode is unchanged between the even edge and the assembly edge.
module pixcap_assemble
    import pixcap_pkg::*;
#(
    parameter int HALF_W = 12,
    localparam int PIX_W = 2 * HALF_W
) (
    input  logic              clk_main,
    input  logic              rst_n,
    input  logic              pd_n,
    input  cap_mode_e         mode,
    input  logic [PIX_W-1:0]  data_q,
    input  logic [HALF_W-1:0] hi_half,
    input  logic              de_q,
    input  logic              hs_q,
    input  logic              vs_q,
    input  logic              ctl_q,
    output logic [PIX_W-1:0]  pix_out,
    output logic              pix_vld,
    output logic              hs_out,
    output logic              vs_out,
    output logic              ctl_out
);

    logic [PIX_W-1:0] joined;

    // Form the pixel for the active mode.
    always_comb begin
        if (mode == CAP_WIDE)
            joined = data_q;
        else
            joined = {hi_half, data_q[HALF_W-1:0]};
    end

    // Register pixel and valid, blanked in reset or power down.
    always_ff @(posedge clk_main) begin
        if (!rst_n || !pd_n) begin
            pix_out <= '0;
            pix_vld <= 1'b0;
        end else begin
            pix_out <= joined;
            pix_vld <= de_q;
        end
    end

    // Re-time sync and control to the pixel latency.
    always_ff @(posedge clk_main) begin
        if (!rst_n) begin
            hs_out  <= 1'b0;
            vs_out  <= 1'b0;
            ctl_out <= 1'b0;
        end else begin
            hs_out  <= hs_q;
            vs_out  <= vs_q;
            ctl_out <= ctl_q;
        end
    end

    // R9: power down blanks pixel and valid.
    p_pd_blank_r9: assert property (@(posedge clk_main) disable iff (!rst_n)
        !$past(pd_n) |-> (!pix_vld && pix_out == '0));

endmodule

// File: rtl/pixcap_top.sv
// Configurable pixel input capture: wide single-edge, narrow dual-edge and
// narrow two-clock modes feeding one 24-bit stream in the clk_main domain.
// Assumes: mode pins static during traffic; clk_odd locked to clk_main.
module pixcap_top
    import pixcap_pkg::*;
#(
    parameter int HALF_W  = 12,
    parameter int CFG_W   = 8,
    parameter int CFG_LSB = 16,
    localparam int PIX_W  = 2 * HALF_W
) (
    input  logic             clk_main,
    input  logic             clk_odd,
    input  logic             rst_n,
    input  logic             pd_n,
    input  logic             wide_sel,
    input  logic             dual_edge_sel,
    input  logic [PIX_W-1:0] din,
    input  logic             de_in,
    input  logic             hs_in,
    input  logic             vs_in,
    input  logic             ctl_in,
    input  logic             ctl_pass_en,
    output logic [PIX_W-1:0] pix_out,
    output logic             pix_vld,
    output logic             hs_out,
    output logic             vs_out,
    output logic             ctl_out,
    output logic [CFG_W-1:0] cfg_out
);

    cap_mode_e         mode;
    logic [PIX_W-1:0]  data_q;
    logic [HALF_W-1:0] hi_half;
    logic              de_q, hs_q, vs_q, ctl_q;

    // Decode the mode pins once for all stages.
    always_comb begin
        mode = decode_mode(wide_sel, dual_edge_sel);
    end

    pixcap_even_stage #(.PIX_W(PIX_W)) u_even (
        .clk_main(clk_main), .rst_n(rst_n), .din(din), .de_in(de_in),
        .hs_in(hs_in), .vs_in(vs_in), .ctl_in(ctl_in),
        .ctl_pass_en(ctl_pass_en), .data_q(data_q), .de_q(de_q),
        .hs_q(hs_q), .vs_q(vs_q), .ctl_q(ctl_q)
    );

    pixcap_odd_stage #(.HALF_W(HALF_W)) u_odd (
        .clk_main(clk_main), .clk_odd(clk_odd), .rst_n(rst_n), .mode(mode),
        .din_lo(din[HALF_W-1:0]), .hi_half(hi_half)
    );

    pixcap_cfg_reg #(.CFG_W(CFG_W)) u_cfg (
        .clk_main(clk_main), .rst_n(rst_n), .narrow(!wide_sel),
        .cfg_pins(din[CFG_LSB +: CFG_W]), .cfg_q(cfg_out)
    );

    pixcap_assemble #(.HALF_W(HALF_W)) u_asm (
        .clk_main(clk_main), .rst_n(rst_n), .pd_n(pd_n), .mode(mode),
        .data_q(data_q), .hi_half(hi_half), .de_q(de_q), .hs_q(hs_q),
        .vs_q(vs_q), .ctl_q(ctl_q), .pix_out(pix_out), .pix_vld(pix_vld),
        .hs_out(hs_out), .vs_out(vs_out), .ctl_out(ctl_out)
    );

    // R5: a valid flag needs DE high at the even edge two edges back.
    p_vld_from_de_r5: assert property (@(posedge clk_main) disable iff (!rst_n)
        pix_vld |-> $past(de_in, 2));

    // R6: syncs keep the pixel latency.
    p_sync_align_r6: assert property (@(posedge clk_main) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, 2)) |->
        (hs_out == $past(hs_in, 2) && vs_out == $past(vs_in, 2)));

    // R8: control passes only when enabled.
    p_ctl_gate_r8: assert property (@(posedge clk_main) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, 2)) |->
        ctl_out == ($past(ctl_in, 2) && $past(ctl_pass_en, 2)));

endmodule

// File: tb/pixcap_top_test.sv
module pixcap_top_test;

    localparam int CLK_PERIOD = 10;

    logic        clk_main = 1'b0;
    logic        fast_clk = 1'b0;
    logic [1:0]  odd_sel  = 2'd0;
    logic        clk_odd;
    logic        rst_n = 1'b0, pd_n = 1'b1;
    logic        wide_sel = 1'b1, dual_edge_sel = 1'b1;
    logic [23:0] din = '0;
    logic        de_in = 0, hs_in = 0, vs_in = 0, ctl_in = 0, ctl_pass_en = 0;
    logic [23:0] pix_out;
    logic        pix_vld, hs_out, vs_out, ctl_out;
    logic [7:0]  cfg_out;
    int          checks = 0, errors = 0;

    always #(CLK_PERIOD / 2) clk_main = ~clk_main;
    always #2 fast_clk = ~fast_clk;
    assign clk_odd = (odd_sel == 2'd0) ? ~clk_main :
                     (odd_sel == 2'd1) ? fast_clk : 1'b0;

    pixcap_top uut (
        .clk_main(clk_main), .clk_odd(clk_odd), .rst_n(rst_n), .pd_n(pd_n),
        .wide_sel(wide_sel), .dual_edge_sel(dual_edge_sel), .din(din),
        .de_in(de_in), .hs_in(hs_in), .vs_in(vs_in), .ctl_in(ctl_in),
        .ctl_pass_en(ctl_pass_en), .pix_out(pix_out), .pix_vld(pix_vld),
        .hs_out(hs_out), .vs_out(vs_out), .ctl_out(ctl_out), .cfg_out(cfg_out)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Drive one pixel (even edge k, odd half after it), return after edge k+1.
    task automatic send(input logic [23:0] px, input logic [7:0] cfgv,
                        input logic de, input logic hs, input logic vs, input logic ctl);
        @(negedge clk_main); #1;
        din   = wide_sel ? px : {cfgv, 4'h0, px[11:0]};
        de_in = de; hs_in = hs; vs_in = vs; ctl_in = ctl;
        @(posedge clk_main); #1;
        if (!wide_sel) din = {cfgv, 4'h0, px[23:12]};
        @(negedge clk_main); #1;
        de_in = 1'b0;
        @(posedge clk_main); #1;
    endtask

    task automatic t_reset;
        repeat (3) @(posedge clk_main);
        #1;
        chk("R10 pix", pix_out, 0);
        chk("R10 vld", pix_vld, 0);
        chk("R10 sync", {hs_out, vs_out, ctl_out}, 0);
        chk("R10 cfg", cfg_out, 0);
        @(negedge clk_main); #1;
        rst_n = 1'b1;
    endtask

    task automatic t_wide;
        wide_sel = 1; ctl_pass_en = 1;
        send(24'hA5C3E1, 8'h00, 1, 1, 0, 1);
        chk("R1 pix", pix_out, 24'hA5C3E1);
        chk("R5 vld", pix_vld, 1);
        chk("R6 sync", {hs_out, vs_out}, 2'b10);
        chk("R8 ctl on", ctl_out, 1);
        @(posedge clk_main); #1;
        chk("R5 single pulse", pix_vld, 0);
        chk("R7 hold wide", cfg_out, 0);
    endtask

    task automatic t_dual;
        wide_sel = 0; dual_edge_sel = 1; ctl_pass_en = 0;
        send(24'h123456, 8'h9B, 1, 0, 1, 1);
        chk("R2 pix", pix_out, 24'h123456);
        chk("R6 vs", {hs_out, vs_out}, 2'b01);
        chk("R8 ctl off", ctl_out, 0);
        chk("R7 cfg", cfg_out, 8'h9B);
        odd_sel = 2'd1;
        send(24'hFEDCBA, 8'h3C, 1, 0, 0, 0);
        chk("R4 dual fast clk_odd", pix_out, 24'hFEDCBA);
        odd_sel = 2'd0;
    endtask

    task automatic t_two_clk;
        wide_sel = 0; dual_edge_sel = 0;
        send(24'h0F0E0D, 8'h11, 1, 0, 0, 0);
        chk("R3 pix", pix_out, 24'h0F0E0D);
        chk("R5 vld", pix_vld, 1);
        @(posedge clk_main); #1;
        odd_sel = 2'd2;
        send(24'h777888, 8'h11, 1, 0, 0, 0);
        chk("R3 stopped clk_odd", pix_out, 24'h0F0888);
        odd_sel = 2'd0;
        send(24'h321CBA, 8'h11, 0, 0, 0, 0);
        chk("R5 de low", pix_vld, 0);
        chk("R3 pix de low", pix_out, 24'h321CBA);
    endtask

    task automatic t_wide_odd_ignored;
        wide_sel = 1; odd_sel = 2'd1;
        send(24'h5A5A5A, 8'h00, 1, 0, 0, 0);
        chk("R4 wide fast clk_odd", pix_out, 24'h5A5A5A);
        chk("R7 hold after narrow", cfg_out, 8'h11);
        odd_sel = 2'd0;
    endtask

    task automatic t_powerdown;
        wide_sel = 1;
        pd_n = 0;
        send(24'hFFFFFF, 8'h00, 1, 0, 0, 0);
        chk("R9 pix", pix_out, 0);
        chk("R9 vld", pix_vld, 0);
        pd_n = 1;
        send(24'h00C0DE, 8'h00, 1, 0, 0, 0);
        chk("R9 resume", pix_out, 24'h00C0DE);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        checks++; errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_wide();
        t_dual();
        t_two_clk();
        t_wide_odd_ignored();
        t_powerdown();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule